// File: doc/BRIEF.md
# Power Gating Sequence Controller

This block sequences power removal and restoration for a single switchable subsystem. It drives two outputs: an isolation control and a power switch enable. It always changes them in a safe order. On the way down, isolation goes up first and the switch opens afterwards. On the way up, the switch closes first and isolation is released afterwards. A separate programmable wait is spent before each of the four edges.

A small word-addressed register port holds four things: the enable that decides whether power-down requests are obeyed, the two power-up waits, the two power-down waits, and a sticky status flag telling whether the most recent power-down request really removed power. The enable is captured once, when a power-down request is accepted. That captured value governs the whole down/up cycle.

The waits count on a clock-enable tick, so they can advance at a slow rate while the register port runs on the bus clock. A ready flag tells the surrounding logic that the subsystem is fully powered and usable.

Top module: `pwr_gate_seq`

## Requirements
- R1: Out of reset the subsystem is powered: sw_on=1, iso=0, ready=1, and all four registers read zero.
- R2: Register words are selected by reg_addr[3:2]. Word 0 (0x0) holds the enable in bit 0. Word 1 (0x4) holds the switch-on wait in bits 5:0 and the isolation-release wait in bits 13:8. Word 2 (0x8) holds the isolation wait in bits 5:0 and the switch-off wait in bits 13:8. Word 3 (0xC) holds the status flag in bit 0. Every other bit reads zero.
- R3: When a power-down request is accepted with the enable at 1, iso rises on the (isolation wait + 1)-th tick. sw_on then falls on the (switch-off wait + 1)-th tick after iso rose.
- R4: When a power-up request arrives in the powered-off state, sw_on rises on the (switch-on wait + 1)-th tick. iso then falls on the (isolation-release wait + 1)-th tick after sw_on rose.
- R5: Whenever sw_on is 0, iso is 1. sw_on and iso never fall in the same cycle: each one falls only while the other is 1.
- R6: A power-down request accepted with the enable at 0 leaves iso, sw_on and ready unchanged and sets the status flag to 0.
- R7: The enable is sampled only when a power-down request is accepted. Writing it during a sequence has no effect on that sequence. After a skipped request, further power-down requests are ignored until a power-up request arrives.
- R8: The status flag becomes 1 when power is removed. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: ready is 1 only in the fully powered, idle state. A power-up request while powered (and not skipped), or a power-down request while powered off, has no effect.
- R10: The waits advance only in cycles where tick is 1.
- R11: Each wait value is sampled when its waiting state is entered. Rewriting the register during that wait does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the wait counters |
| pdn_req | input | 1 | Power-down request, sampled each clock |
| pup_req | input | 1 | Power-up request, sampled each clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| iso | output | 1 | Isolation control, active high |
| sw_on | output | 1 | Power switch enable, active high |
| ready | output | 1 | Subsystem powered and idle |

## Verification
Full down/up cycles are run with three delay sets: all zero, small unequal values, and the maximum on one side with zero on the other. Together they separate an off-by-one in the wait count from a mix-up between the four fields. Runs with the enable cleared, and with it rewritten mid-sequence, tell a per-request captured copy apart from a live read. A sparse tick pattern and a mid-wait register rewrite show that waits count ticks rather than clocks, and that they take the delay value present at state entry.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   typedef enum logic [2:0] {
      ST_ON          = 3'd0,
      ST_ISO_WAIT    = 3'd1,
      ST_SWOFF_WAIT  = 3'd2,
      ST_OFF         = 3'd3,
      ST_SWON_WAIT   = 3'd4,
      ST_ISOREL_WAIT = 3'd5
   } pgs_state_e;

   typedef enum logic [1:0] {
      DSEL_DN_ISO = 2'd0,
      DSEL_DN_SW  = 2'd1,
      DSEL_UP_SW  = 2'd2,
      DSEL_UP_ISO = 2'd3
   } pgs_dsel_e;

   localparam int unsigned WIDX_CTRL = 0;
   localparam int unsigned WIDX_UP   = 1;
   localparam int unsigned WIDX_DN   = 2;
   localparam int unsigned WIDX_STAT = 3;
   localparam int unsigned HI_LSB    = 8;

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
   import pgs_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DLY_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              stat_set,
   input  logic              stat_clr,
   output logic              pd_enable,
   output logic [DLY_W-1:0]  up_sw,
   output logic [DLY_W-1:0]  up_iso,
   output logic [DLY_W-1:0]  dn_iso,
   output logic [DLY_W-1:0]  dn_sw
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic             ctrl_q;
   logic [DLY_W-1:0] up_sw_q, up_iso_q, dn_iso_q, dn_sw_q;
   logic             stat_q;
   logic             unused_bits;

   assign widx        = addr[ADDR_W-1:2];
   assign unused_bits = ^{addr[1:0], wdata};

   function automatic logic [DATA_W-1:0] pack_pair(input logic [DLY_W-1:0] lo,
                                                   input logic [DLY_W-1:0] hi);
      logic [DATA_W-1:0] v;
      v = '0;
      v[DLY_W-1:0]               = lo;
      v[HI_LSB+DLY_W-1:HI_LSB]   = hi;
      return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= 1'b0;
         up_sw_q  <= '0;
         up_iso_q <= '0;
         dn_iso_q <= '0;
         dn_sw_q  <= '0;
      end else if (wr_en) begin
         if (widx == IDX_W'(WIDX_CTRL)) ctrl_q <= wdata[0];
         if (widx == IDX_W'(WIDX_UP)) begin
            up_sw_q  <= wdata[DLY_W-1:0];
            up_iso_q <= wdata[HI_LSB+DLY_W-1:HI_LSB];
         end
         if (widx == IDX_W'(WIDX_DN)) begin
            dn_iso_q <= wdata[DLY_W-1:0];
            dn_sw_q  <= wdata[HI_LSB+DLY_W-1:HI_LSB];
         end
      end
   end

   // Hardware events take precedence over a software clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= 1'b0;
      else if (stat_set)
         stat_q <= 1'b1;
      else if (stat_clr)
         stat_q <= 1'b0;
      else if (wr_en && widx == IDX_W'(WIDX_STAT) && wdata[0])
         stat_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (widx)
         IDX_W'(WIDX_CTRL): rdata[0] = ctrl_q;
         IDX_W'(WIDX_UP):   rdata    = pack_pair(up_sw_q, up_iso_q);
         IDX_W'(WIDX_DN):   rdata    = pack_pair(dn_iso_q, dn_sw_q);
         IDX_W'(WIDX_STAT): rdata[0] = stat_q;
         default:           rdata    = '0;
      endcase
   end

   assign pd_enable = ctrl_q;
   assign up_sw     = up_sw_q;
   assign up_iso    = up_iso_q;
   assign dn_iso    = dn_iso_q;
   assign dn_sw     = dn_sw_q;

endmodule

// File: rtl/pgs_delay.sv
module pgs_delay #(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] ld_val,
   input  logic             step,
   output logic             zero
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= ld_val;
      else if (step && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
   import pgs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      zero,
   input  logic      pdn_req,
   input  logic      pup_req,
   input  logic      pd_enable,
   output logic      load,
   output pgs_dsel_e dsel,
   output logic      iso,
   output logic      sw_on,
   output logic      ready,
   output logic      stat_set,
   output logic      stat_clr
);

   pgs_state_e state_q, state_d;
   logic       iso_q, iso_d;
   logic       sw_q, sw_d;
   logic       skip_q, skip_d;   // captured enable of the current cycle, inverted
   logic       expire;

   assign expire = step && zero;

   always_comb begin
      state_d  = state_q;
      iso_d    = iso_q;
      sw_d     = sw_q;
      skip_d   = skip_q;
      load     = 1'b0;
      dsel     = DSEL_DN_ISO;
      stat_set = 1'b0;
      stat_clr = 1'b0;
      case (state_q)
         ST_ON: begin
            if (pdn_req && !skip_q) begin
               if (pd_enable) begin
                  state_d = ST_ISO_WAIT;
                  load    = 1'b1;
                  dsel    = DSEL_DN_ISO;
               end else begin
                  skip_d   = 1'b1;
                  stat_clr = 1'b1;
               end
            end else if (pup_req && skip_q) begin
               skip_d = 1'b0;
            end
         end
         ST_ISO_WAIT: begin
            if (expire) begin
               iso_d   = 1'b1;
               state_d = ST_SWOFF_WAIT;
               load    = 1'b1;
               dsel    = DSEL_DN_SW;
            end
         end
         ST_SWOFF_WAIT: begin
            if (expire) begin
               sw_d     = 1'b0;
               state_d  = ST_OFF;
               stat_set = 1'b1;
            end
         end
         ST_OFF: begin
            if (pup_req) begin
               state_d = ST_SWON_WAIT;
               load    = 1'b1;
               dsel    = DSEL_UP_SW;
            end
         end
         ST_SWON_WAIT: begin
            if (expire) begin
               sw_d    = 1'b1;
               state_d = ST_ISOREL_WAIT;
               load    = 1'b1;
               dsel    = DSEL_UP_ISO;
            end
         end
         ST_ISOREL_WAIT: begin
            if (expire) begin
               iso_d   = 1'b0;
               state_d = ST_ON;
            end
         end
         default: begin
            state_d = ST_ON;
            iso_d   = 1'b0;
            sw_d    = 1'b1;
            skip_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ON;
         iso_q   <= 1'b0;
         sw_q    <= 1'b1;
         skip_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         iso_q   <= iso_d;
         sw_q    <= sw_d;
         skip_q  <= skip_d;
      end
   end

   assign iso   = iso_q;
   assign sw_on = sw_q;
   assign ready = (state_q == ST_ON);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
   import pgs_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DLY_W    = 6,
   parameter bit          USE_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pdn_req,
   input  logic              pup_req,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              iso,
   output logic              sw_on,
   output logic              ready
);

   localparam int unsigned FIELD_TOP = HI_LSB + DLY_W;

   if (DLY_W < 1 || DLY_W > HI_LSB) begin : g_bad_dly
      $error("pwr_gate_seq: DLY_W must lie in 1..8");
   end
   if (DATA_W < FIELD_TOP) begin : g_bad_data
      $error("pwr_gate_seq: DATA_W too narrow for the delay fields");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pwr_gate_seq: ADDR_W must be at least 4");
   end

   logic             step;
   logic             zero, load;
   pgs_dsel_e        dsel;
   logic             pd_enable, stat_set, stat_clr;
   logic [DLY_W-1:0] up_sw, up_iso, dn_iso, dn_sw;
   logic [DLY_W-1:0] ld_val;

   if (USE_TICK) begin : g_tick
      assign step = tick;
   end else begin : g_free
      logic unused_tick;
      assign unused_tick = tick;
      assign step        = 1'b1;
   end

   always_comb begin
      case (dsel)
         DSEL_DN_ISO: ld_val = dn_iso;
         DSEL_DN_SW:  ld_val = dn_sw;
         DSEL_UP_SW:  ld_val = up_sw;
         default:     ld_val = up_iso;
      endcase
   end

   pgs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .stat_set  (stat_set),
      .stat_clr  (stat_clr),
      .pd_enable (pd_enable),
      .up_sw     (up_sw),
      .up_iso    (up_iso),
      .dn_iso    (dn_iso),
      .dn_sw     (dn_sw)
   );

   pgs_delay #(.DLY_W(DLY_W)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .ld_val (ld_val),
      .step   (step),
      .zero   (zero)
   );

   pgs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .zero      (zero),
      .pdn_req   (pdn_req),
      .pup_req   (pup_req),
      .pd_enable (pd_enable),
      .load      (load),
      .dsel      (dsel),
      .iso       (iso),
      .sw_on     (sw_on),
      .ready     (ready),
      .stat_set  (stat_set),
      .stat_clr  (stat_clr)
   );

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk (
   input logic clk,
   input logic rst_n,
   input logic iso,
   input logic sw_on,
   input logic ready
);

   // R5
   off_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_on |-> iso);

   // R5
   sw_fall_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_on) |-> (iso && $past(iso)));

   // R5
   iso_fall_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso) |-> (sw_on && $past(sw_on)));

   // R9
   ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sw_on && !iso));

   // R3
   iso_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso) |-> (!ready && !$past(ready) && sw_on));

   // R4
   sw_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_on) |-> (iso && !ready));

endmodule

bind pwr_gate_seq pgs_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .iso   (iso),
   .sw_on (sw_on),
   .ready (ready)
);

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        pdn_req = 1'b0;
   logic        pup_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        iso, sw_on, ready;

   int total = 0;
   int bad = 0;
   int tick_mode = 0;
   int tdiv = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   pwr_gate_seq u_pwr_gate_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pdn_req   (pdn_req),
      .pup_req   (pup_req),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .iso       (iso),
      .sw_on     (sw_on),
      .ready     (ready)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (tick_mode == 0) begin
         tick <= 1'b1;
      end else begin
         tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
         tick <= (tdiv == 2);
      end
   end

   initial begin
      wait (cyc > 100000);
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic req_down();
      pdn_req = 1'b1;
      @(negedge clk);
      pdn_req = 1'b0;
   endtask

   task automatic req_up();
      pup_req = 1'b1;
      @(negedge clk);
      pup_req = 1'b0;
   endtask

   // which: 0 = iso, 1 = sw_on. Counts ticks seen until the output equals val.
   task automatic wait_for(input int which, input logic val, output int nt, output int nc);
      logic cur, t;
      nt = 0;
      nc = 0;
      cur = (which == 0) ? iso : sw_on;
      while (cur != val && nc < 2000) begin
         t = tick;
         @(negedge clk);
         nc = nc + 1;
         if (t) nt = nt + 1;
         cur = (which == 0) ? iso : sw_on;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_seq(input int up_s, input int up_i, input int dn_i, input int dn_s);
      wr(4'h4, 32'(up_s) | (32'(up_i) << 8));
      wr(4'h8, 32'(dn_i) | (32'(dn_s) << 8));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 sw_on", int'(sw_on), 1);
      check("R1 iso", int'(iso), 0);
      check("R1 ready", int'(ready), 1);
      for (int a = 0; a < 16; a += 4) begin
         rd(4'(a), d);
         check("R1 reg zero", int'(d), 0);
      end
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R2 ctrl mask", int'(d), 1);
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, d); check("R2 up mask", int'(d), 32'h3F3F);
      wr(4'h8, 32'h1234_5678);
      rd(4'h8, d); check("R2 down fields", int'(d), 32'h1638);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, d); check("R2 status mask", int'(d), 0);
      wr(4'h0, 32'h0);
   endtask

   task automatic t_cycle(input int up_s, input int up_i, input int dn_i, input int dn_s);
      int nt, nc;
      logic [31:0] d;
      wr(4'h0, 32'h1);
      set_seq(up_s, up_i, dn_i, dn_s);
      req_down();
      check("R9 ready low in sequence", int'(ready), 0);
      wait_for(0, 1'b1, nt, nc);
      check("R3 iso delay", nt, dn_i + 1);
      check("R5 power held at iso rise", int'(sw_on), 1);
      wait_for(1, 1'b0, nt, nc);
      check("R3 switch-off delay", nt, dn_s + 1);
      rd(4'hC, d); check("R8 status set", int'(d), 1);
      req_up();
      wait_for(1, 1'b1, nt, nc);
      check("R4 switch-on delay", nt, up_s + 1);
      check("R5 iso held at switch-on", int'(iso), 1);
      wait_for(0, 1'b0, nt, nc);
      check("R4 iso release delay", nt, up_i + 1);
      check("R9 ready after up", int'(ready), 1);
   endtask

   task automatic t_disabled();
      int nt, nc;
      int bad_seen;
      logic [31:0] d;
      set_seq(1, 1, 2, 2);
      wr(4'h0, 32'h0);
      req_down();
      bad_seen = 0;
      for (int i = 0; i < 20; i++) begin
         if (iso !== 1'b0 || sw_on !== 1'b1 || ready !== 1'b1) bad_seen++;
         @(negedge clk);
      end
      check("R6 outputs unchanged when disabled", bad_seen, 0);
      rd(4'hC, d); check("R6 status cleared on skip", int'(d), 0);
      wr(4'h0, 32'h1);
      req_down();
      idle(20);
      check("R7 request ignored while skipped", int'(iso), 0);
      check("R7 power kept while skipped", int'(sw_on), 1);
      req_up();
      req_down();
      wait_for(0, 1'b1, nt, nc);
      check("R7 new request after up", nt, 3);
      wait_for(1, 1'b0, nt, nc);
      req_up();
      wait_for(0, 1'b0, nt, nc);
      check("R7 back on", int'(ready), 1);
   endtask

   task automatic t_latch();
      int nt, nc;
      set_seq(0, 0, 4, 4);
      wr(4'h0, 32'h1);
      req_down();
      wr(4'h0, 32'h0);
      wait_for(1, 1'b0, nt, nc);
      check("R7 power removed despite enable cleared", int'(sw_on), 0);
      req_up();
      wait_for(0, 1'b0, nt, nc);
      wr(4'h0, 32'h1);
   endtask

   task automatic t_status_ignore();
      int nt, nc;
      logic [31:0] d;
      set_seq(2, 2, 1, 1);
      wr(4'h0, 32'h1);
      req_up();
      idle(10);
      check("R9 power-up ignored while on", int'(ready) + int'(iso) * 2, 1);
      req_down();
      wait_for(1, 1'b0, nt, nc);
      req_down();
      idle(10);
      check("R9 power-down ignored while off", int'(sw_on) + int'(iso) * 2, 2);
      check("R9 ready low when off", int'(ready), 0);
      wr(4'hC, 32'h0);
      rd(4'hC, d); check("R8 write 0 keeps status", int'(d), 1);
      wr(4'hC, 32'h1);
      rd(4'hC, d); check("R8 write 1 clears status", int'(d), 0);
      req_up();
      wait_for(0, 1'b0, nt, nc);
   endtask

   task automatic t_tick();
      int nt, nc;
      set_seq(3, 2, 4, 5);
      wr(4'h0, 32'h1);
      tick_mode = 1;
      req_down();
      wait_for(0, 1'b1, nt, nc);
      check("R10 iso wait in ticks", nt, 5);
      check("R10 cycles exceed ticks", int'(nc > nt), 1);
      wait_for(1, 1'b0, nt, nc);
      check("R10 switch-off wait in ticks", nt, 6);
      req_up();
      wait_for(1, 1'b1, nt, nc);
      check("R10 switch-on wait in ticks", nt, 4);
      wait_for(0, 1'b0, nt, nc);
      check("R10 release wait in ticks", nt, 3);
      tick_mode = 0;
      idle(2);
   endtask

   task automatic t_sample();
      int nt, nc;
      set_seq(0, 0, 10, 0);
      wr(4'h0, 32'h1);
      req_down();
      wr(4'h8, 32'h0000_0001);
      wait_for(0, 1'b1, nt, nc);
      check("R11 wait length fixed at entry", nt + 1, 11);
      wait_for(1, 1'b0, nt, nc);
      req_up();
      wait_for(0, 1'b0, nt, nc);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_regs();
      t_cycle(0, 0, 0, 0);
      t_cycle(2, 7, 3, 5);
      t_cycle(40, 0, 63, 1);
      t_disabled();
      t_latch();
      t_status_ignore();
      t_tick();
      t_sample();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule